// File: doc/BRIEF.md
# Conditional Signaling Floating-Point Comparator

This block compares two scalar floating-point operands and turns the outcome into a 4-bit flag word ordered {N, Z, C, V}. It handles three operand widths: 16-bit half, 32-bit single and 64-bit double precision. The operand sits in the low bits of a 64-bit input. Before it compares anything, the block tests a 4-bit condition code against the caller's current flags. If that test fails, the block skips the compare and passes a caller-supplied 4-bit immediate straight through as the result.

The compare is of the signaling kind. Whenever a compare is actually performed and either operand is a NaN, quiet or signaling, the block raises an invalid-operation indication alongside the unordered flag pattern. Results come out of a single register stage with a valid strobe. A pipeline issues one request per cycle and reads the new flags one cycle later.

Top module: `fp_cond_cmp`

## Requirements
- R1: `fmt` selects the operand format: 0 = half (bits 15:0), 1 = single (bits 31:0), 2 = double (bits 63:0), 3 = treated as double. Operand bits above the selected width have no effect on the result.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. Synchronous reset clears `out_valid`, `out_nzcv` and `out_invalid` to 0.
- R3: When the condition fails on `cur_nzcv`, `out_nzcv` equals `imm_nzcv` and `out_invalid` is 0.
- R4: Conditions are evaluated on `cur_nzcv` = {N,Z,C,V} with codes 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 !(!Z&(N==V)), and codes 14 and 15 always pass.
- R5: When a compare is performed, `out_nzcv` is 1000 for a<b, 0110 for a==b, 0010 for a>b and 0011 for unordered. No other value results.
- R6: A NaN (exponent all ones, nonzero fraction; quiet when the top fraction bit is 1, signaling when it is 0) in either operand gives unordered and sets `out_invalid`, but only when the condition passes.
- R7: +0 and -0 compare equal, infinities order by sign, and subnormals compare by exact value without flushing.
- R8: Finite values order by sign first and then by magnitude, with the order reversed when both operands are negative.
- R9: In a cycle without `in_valid`, `out_nzcv` keeps its value and `out_invalid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Operand format select |
| op_a | input | 64 | First operand, low-aligned |
| op_b | input | 64 | Second operand, low-aligned |
| cond | input | 4 | Condition code |
| cur_nzcv | input | 4 | Current flags {N,Z,C,V} |
| imm_nzcv | input | 4 | Substitute flags used when the condition fails |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_nzcv | output | 4 | Resulting flags {N,Z,C,V} |
| out_invalid | output | 1 | Invalid-operation indication |

## Verification
The properties assume that `in_valid` is low while reset is asserted, so that no request straddles the reset edge. The self-compare property assumes that a double operand whose exponent is not all ones is an ordered value. The bench deasserts `in_valid` throughout reset. It drives every input half a cycle away from the sampling edge, and it draws operands only from well-formed bit patterns of the selected format, with random junk placed in the unused upper bits. This keeps every request inside these assumptions.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int DATA_W = 64;
    localparam int MAG_W  = DATA_W - 1;

    localparam int HALF_EXP_W = 5;
    localparam int HALF_FRC_W = 10;
    localparam int SNGL_EXP_W = 8;
    localparam int SNGL_FRC_W = 23;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRC_W  = 52;
    localparam int NUM_FMT    = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_WIDE   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    function automatic int fmt_exp_w(int idx);
        case (idx)
            0:       return HALF_EXP_W;
            1:       return SNGL_EXP_W;
            default: return DBL_EXP_W;
        endcase
    endfunction

    function automatic int fmt_frc_w(int idx);
        case (idx)
            0:       return HALF_FRC_W;
            1:       return SNGL_FRC_W;
            default: return DBL_FRC_W;
        endcase
    endfunction

    function automatic logic [3:0] order_to_flags(order_e o);
        case (o)
            ORD_LT:  return 4'b1000;
            ORD_EQ:  return 4'b0110;
            ORD_GT:  return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/fpcc_field.sv
module fpcc_field
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int FRC_W = 52
) (
    input  logic [EXP_W+FRC_W:0] bits,
    output opnd_t                opnd
);
    localparam int BODY_W = EXP_W + FRC_W;

    logic [EXP_W-1:0] exp_f;
    logic [FRC_W-1:0] frc_f;

    always_comb begin
        exp_f        = bits[BODY_W-1:FRC_W];
        frc_f        = bits[FRC_W-1:0];
        opnd.sign    = bits[BODY_W];
        opnd.is_nan  = (&exp_f) && (|frc_f);
        opnd.is_zero = ~|bits[BODY_W-1:0];
        opnd.mag     = MAG_W'(bits[BODY_W-1:0]);
    end
endmodule

// File: rtl/fpcc_decode.sv
module fpcc_decode
    import fpcc_pkg::*;
(
    input  logic [1:0]        fmt,
    input  logic [DATA_W-1:0] raw,
    output opnd_t             opnd
);
    opnd_t per_fmt [NUM_FMT];

    for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_fmt
        localparam int EW = fmt_exp_w(gi);
        localparam int FW = fmt_frc_w(gi);
        fpcc_field #(.EXP_W(EW), .FRC_W(FW)) u_field (
            .bits (raw[EW+FW:0]),
            .opnd (per_fmt[gi])
        );
    end

    always_comb begin
        case (fmt_e'(fmt))
            FMT_HALF:   opnd = per_fmt[0];
            FMT_SINGLE: opnd = per_fmt[1];
            default:    opnd = per_fmt[2];
        endcase
    end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
    import fpcc_pkg::*;
(
    input  opnd_t  a,
    input  opnd_t  b,
    output order_e ord
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        if (a.is_nan || b.is_nan) begin
            ord = ORD_UN;
        end else if (a.is_zero && b.is_zero) begin
            ord = ORD_EQ;
        end else if (a.sign != b.sign) begin
            ord = a.sign ? ORD_LT : ORD_GT;
        end else if (mag_eq) begin
            ord = ORD_EQ;
        end else if (a.sign) begin
            ord = mag_lt ? ORD_GT : ORD_LT;
        end else begin
            ord = mag_lt ? ORD_LT : ORD_GT;
        end
    end
endmodule

// File: rtl/fpcc_cond.sv
module fpcc_cond (
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic n_f, z_f, c_f, v_f;
    logic base;

    always_comb begin
        {n_f, z_f, c_f, v_f} = flags;
        case (cond[3:1])
            3'd0:    base = z_f;
            3'd1:    base = c_f;
            3'd2:    base = n_f;
            3'd3:    base = v_f;
            3'd4:    base = c_f && !z_f;
            3'd5:    base = (n_f == v_f);
            3'd6:    base = !z_f && (n_f == v_f);
            default: base = 1'b1;
        endcase
        if (cond[3:1] == 3'd7) begin
            pass = 1'b1;
        end else begin
            pass = cond[0] ? !base : base;
        end
    end
endmodule

// File: rtl/fp_cond_cmp.sv
module fp_cond_cmp
    import fpcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  fmt,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic [3:0]  cond,
    input  logic [3:0]  cur_nzcv,
    input  logic [3:0]  imm_nzcv,
    output logic        out_valid,
    output logic [3:0]  out_nzcv,
    output logic        out_invalid
);
    opnd_t  opnd [2];
    order_e ord;
    logic   cond_ok;

    for (genvar gi = 0; gi < 2; gi++) begin : g_dec
        fpcc_decode u_dec (
            .fmt  (fmt),
            .raw  ((gi == 0) ? op_a : op_b),
            .opnd (opnd[gi])
        );
    end

    fpcc_order u_order (
        .a   (opnd[0]),
        .b   (opnd[1]),
        .ord (ord)
    );

    fpcc_cond u_cond (
        .cond  (cond),
        .flags (cur_nzcv),
        .pass  (cond_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_nzcv    <= 4'b0000;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_nzcv    <= cond_ok ? order_to_flags(ord) : imm_nzcv;
                out_invalid <= cond_ok && (ord == ORD_UN);
            end else begin
                out_invalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fpcc_checker.sv
module fpcc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  fmt,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [3:0]  cond,
    input logic [3:0]  cur_nzcv,
    input logic [3:0]  imm_nzcv,
    input logic        out_valid,
    input logic [3:0]  out_nzcv,
    input logic        out_invalid
);
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_lat_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_cond_fail_imm_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd0 && !cur_nzcv[2])
        |=> (out_nzcv == $past(imm_nzcv)) && !out_invalid);

    p_always_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'hE)
        |=> (out_nzcv == 4'b1000 || out_nzcv == 4'b0110 ||
             out_nzcv == 4'b0010 || out_nzcv == 4'b0011));

    p_invalid_unord_r6: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_nzcv == 4'b0011) && out_valid);

    p_self_equal_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'hF && fmt == 2'd2 && op_a == op_b &&
         op_a[62:52] != 11'h7FF)
        |=> out_nzcv == 4'b0110);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_nzcv) && !out_invalid);
endmodule

bind fp_cond_cmp fpcc_checker u_chk (.*);

// File: tb/fp_cond_cmp_test.sv
`timescale 1ns/1ps
module fp_cond_cmp_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  cond = 4'd0;
    logic [3:0]  cur_nzcv = 4'd0;
    logic [3:0]  imm_nzcv = 4'd0;
    logic        out_valid;
    logic [3:0]  out_nzcv;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fp_cond_cmp uut (.*);

    function automatic int ew_of(logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
    endfunction
    function automatic int fw_of(logic [1:0] f);
        return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
    endfunction

    function automatic logic [63:0] build(logic [1:0] f, logic s, longint e, longint fr);
        int ew = ew_of(f);
        int fw = fw_of(f);
        logic [63:0] v;
        v = (64'(s) << (ew + fw)) | (64'(e) << fw) | 64'(fr);
        return v;
    endfunction

    // kinds: 0 zero,1 inf,2 qnan,3 snan,4 min sub,5 max sub,6 min norm,7 one,8 two,9 max fin,10 random
    function automatic logic [63:0] special(logic [1:0] f, int kind, logic s);
        int ew = ew_of(f);
        int fw = fw_of(f);
        longint emax = (longint'(1) << ew) - 1;
        longint bias = (longint'(1) << (ew - 1)) - 1;
        longint fmax = (longint'(1) << fw) - 1;
        case (kind)
            0:  return build(f, s, 0, 0);
            1:  return build(f, s, emax, 0);
            2:  return build(f, s, emax, longint'(1) << (fw - 1));
            3:  return build(f, s, emax, 1);
            4:  return build(f, s, 0, 1);
            5:  return build(f, s, 0, fmax);
            6:  return build(f, s, 1, 0);
            7:  return build(f, s, bias, 0);
            8:  return build(f, s, bias + 1, 0);
            9:  return build(f, s, emax - 1, fmax);
            default: return build(f, s, longint'($urandom_range(0, 32'(emax))),
                                  ({longint'($urandom), longint'($urandom)} >> 0) & fmax);
        endcase
    endfunction

    function automatic logic [63:0] with_junk(logic [1:0] f, logic [63:0] v);
        int w = 1 + ew_of(f) + fw_of(f);
        logic [63:0] junk = {$urandom, $urandom};
        if (w >= 64) return v;
        return (junk << w) | (v & ((64'd1 << w) - 1));
    endfunction

    function automatic bit is_nan_ref(logic [1:0] f, logic [63:0] v);
        int ew = ew_of(f);
        int fw = fw_of(f);
        longint e = longint'((v >> fw) & ((64'd1 << ew) - 1));
        longint fr = longint'(v & ((64'd1 << fw) - 1));
        return (e == (longint'(1) << ew) - 1) && (fr != 0);
    endfunction

    function automatic real value_of(logic [1:0] f, logic [63:0] v);
        int ew = ew_of(f);
        int fw = fw_of(f);
        int bias = (1 << (ew - 1)) - 1;
        int e;
        longint fr;
        real mag;
        bit s;
        if (f >= 2'd2) return $bitstoreal(v);
        s  = v[ew + fw];
        e  = int'((v >> fw) & ((64'd1 << ew) - 1));
        fr = longint'(v & ((64'd1 << fw) - 1));
        if (e == (1 << ew) - 1) mag = 1.0e308 * 10.0;
        else if (e == 0) mag = real'(fr) * (2.0 ** (1 - bias - fw));
        else mag = (real'(fr) + 2.0 ** fw) * (2.0 ** (e - bias - fw));
        return s ? -mag : mag;
    endfunction

    function automatic bit cond_ref(logic [3:0] c, logic [3:0] fl);
        bit n = fl[3], z = fl[2], cc = fl[1], v = fl[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cc;
            4'd3:  return !cc;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cc && !z;
            4'd9:  return !(cc && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string req, logic [3:0] got_f, logic [3:0] exp_f,
                         logic got_i, logic exp_i);
        checks++;
        if (got_f !== exp_f || got_i !== exp_i || out_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s: nzcv=%b invalid=%b valid=%b expected nzcv=%b invalid=%b valid=1",
                     req, got_f, got_i, out_valid, exp_f, exp_i);
        end
    endtask

    task automatic run_op(string req, logic [1:0] f, logic [63:0] a, logic [63:0] b,
                          logic [3:0] c, logic [3:0] cur, logic [3:0] imm);
        logic [3:0] ef;
        logic       ei;
        logic [1:0] ff;
        real ra, rb;
        ff = (f == 2'd3) ? 2'd2 : f;
        if (!cond_ref(c, cur)) begin
            ef = imm; ei = 1'b0;
        end else if (is_nan_ref(ff, a) || is_nan_ref(ff, b)) begin
            ef = 4'b0011; ei = 1'b1;
        end else begin
            ra = value_of(ff, a);
            rb = value_of(ff, b);
            ei = 1'b0;
            if (ra < rb) ef = 4'b1000;
            else if (ra > rb) ef = 4'b0010;
            else ef = 4'b0110;
        end
        @(negedge clk);
        in_valid = 1'b1; fmt = f; op_a = a; op_b = b;
        cond = c; cur_nzcv = cur; imm_nzcv = imm;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_nzcv, ef, out_invalid, ei);
    endtask

    initial begin
        #(8ns * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R2: reset state
        checks++;
        if (out_valid !== 1'b0 || out_nzcv !== 4'd0 || out_invalid !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset: valid=%b nzcv=%b invalid=%b expected 0 0000 0",
                     out_valid, out_nzcv, out_invalid);
        end
        rst = 1'b0;
        @(negedge clk);

        // R4: every condition code against every flag pattern, compare 1.0 vs 2.0
        for (int c = 0; c < 16; c++)
            for (int fl = 0; fl < 16; fl++)
                run_op("R4 cond table", 2'd1, special(2'd1, 7, 0), special(2'd1, 8, 0),
                       4'(c), 4'(fl), 4'(15 - fl));

        // R3: failing condition with NaN operand gives immediate and no invalid
        run_op("R3 fail with NaN", 2'd2, special(2'd2, 3, 0), special(2'd2, 7, 0),
               4'd0, 4'b0000, 4'b1011);

        for (int f = 0; f < 3; f++) begin
            // R7: signed zeros equal
            run_op("R7 +0 vs -0", 2'(f), special(2'(f), 0, 0), special(2'(f), 0, 1), 4'hE, 4'd0, 4'd5);
            run_op("R7 -0 vs +0", 2'(f), special(2'(f), 0, 1), special(2'(f), 0, 0), 4'hE, 4'd0, 4'd5);
            // R7: infinities
            run_op("R7 -inf vs +inf", 2'(f), special(2'(f), 1, 1), special(2'(f), 1, 0), 4'hE, 4'd0, 4'd5);
            run_op("R7 +inf vs max", 2'(f), special(2'(f), 1, 0), special(2'(f), 9, 0), 4'hE, 4'd0, 4'd5);
            run_op("R7 inf equal", 2'(f), special(2'(f), 1, 1), special(2'(f), 1, 1), 4'hF, 4'd0, 4'd5);
            // R7: subnormals exact
            run_op("R7 min sub vs zero", 2'(f), special(2'(f), 4, 0), special(2'(f), 0, 0), 4'hE, 4'd0, 4'd5);
            run_op("R7 max sub vs min norm", 2'(f), special(2'(f), 5, 0), special(2'(f), 6, 0), 4'hE, 4'd0, 4'd5);
            // R8: negative ordering reversal
            run_op("R8 -1 vs -2", 2'(f), special(2'(f), 7, 1), special(2'(f), 8, 1), 4'hE, 4'd0, 4'd5);
            run_op("R8 -sub vs +sub", 2'(f), special(2'(f), 4, 1), special(2'(f), 4, 0), 4'hE, 4'd0, 4'd5);
            // R6: NaN in each position, quiet and signaling
            for (int k = 2; k <= 3; k++) begin
                run_op("R6 NaN in a", 2'(f), special(2'(f), k, 0), special(2'(f), 7, 0), 4'hE, 4'd0, 4'd5);
                run_op("R6 NaN in b", 2'(f), special(2'(f), 7, 1), special(2'(f), k, 1), 4'hE, 4'd0, 4'd5);
                run_op("R6 NaN both", 2'(f), special(2'(f), k, 0), special(2'(f), k, 0), 4'hE, 4'd0, 4'd5);
            end
            // R1: junk above the selected width
            run_op("R1 upper junk", 2'(f), with_junk(2'(f), special(2'(f), 7, 0)),
                   with_junk(2'(f), special(2'(f), 7, 0)), 4'hE, 4'd0, 4'd5);
        end
        // R1: code 3 behaves as double
        run_op("R1 fmt 3", 2'd3, special(2'd2, 8, 0), special(2'd2, 7, 0), 4'hE, 4'd0, 4'd5);

        // R9: idle cycle holds flags and drops invalid
        run_op("R6 before idle", 2'd0, special(2'd0, 2, 0), special(2'd0, 7, 0), 4'hE, 4'd0, 4'd5);
        held = out_nzcv;
        op_a = special(2'd0, 7, 0); cond = 4'd1; imm_nzcv = 4'b1111;
        @(negedge clk);
        checks++;
        if (out_nzcv !== held || out_invalid !== 1'b0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 idle: nzcv=%b invalid=%b valid=%b expected nzcv=%b invalid=0 valid=0",
                     out_nzcv, out_invalid, out_valid, held);
        end

        // R1 R3 R5 R6 R7 R8: constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] f;
            logic [63:0] a, b;
            f = 2'($urandom_range(0, 3));
            a = special((f == 2'd3) ? 2'd2 : f, $urandom_range(0, 12), 1'($urandom));
            b = ($urandom_range(0, 7) == 0) ? a
                : special((f == 2'd3) ? 2'd2 : f, $urandom_range(0, 12), 1'($urandom));
            run_op("R5 random", f, with_junk((f == 2'd3) ? 2'd2 : f, a),
                   with_junk((f == 2'd3) ? 2'd2 : f, b),
                   4'($urandom), 4'($urandom), 4'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule